// File: doc/BRIEF.md
# CAN Controller Mode and Interrupt Register Block

This block is the control and status front end of a CAN controller. Software reaches it through a plain 32-bit register port, one word per offset. There it enables or disables the controller, picks an operating mode, reads back which mode is running, and handles the transmit and receive interrupt flags. The protocol engine sits beside it. It sends three single-cycle event pulses: a frame went out, a frame came in, and traffic was seen on the bus. In return the block drives level signals that tell the engine how to behave.

While disabled the controller is in configuration mode. The chosen mode only starts running on the write that moves the enable bit from 0 to 1, so the expected order is: disable, write the mode, enable. A running sleep mode drops back to normal mode by itself as soon as the engine reports bus traffic. After that the controller can take the incoming frame. In loopback the engine's transmitted frame comes back internally as a received one. In listen-only mode nothing may be sent.

Top module: `can_mr_regs`

## Requirements
- R1: After reset the block is disabled and in configuration mode. Every readable word is 0, which includes a mode selection code of 0 (normal), and every engine output is low.
- R2: Bit 1 of the word at offset 0x00 is the enable bit, and it reads back at bit 1. Writing the word with bit 1 clear puts the block back into configuration mode at once.
- R3: The word at offset 0x04 holds the mode selection: 0 normal, 1 sleep, 2 loopback, 4 listen-only. A write of any other 32-bit value leaves the stored code unchanged.
- R4: A write to offset 0x04 while the enable bit is set has no effect.
- R5: The read-only word at offset 0x18 shows the running mode with a single set bit: bit 3 normal, bit 1 loopback, bit 2 sleep, bit 12 listen-only. It reads 0 in configuration mode.
- R6: The stored mode code starts running on a write that changes the enable bit from 0 to 1. Writing the enable bit as 1 again while already enabled keeps the running mode.
- R7: When the engine reports bus activity during sleep, the running mode becomes normal on the next cycle. The stored code at 0x04 does not change.
- R8: At offset 0x1C, bit 1 is set by a transmit-done pulse and bit 4 by a receive-done pulse. Both stay set until cleared. All other bits read 0.
- R9: Writing a word to offset 0x24 clears every flag whose bit position holds a 1. A pulse that sets a flag in the same cycle wins over the clear.
- R10: In configuration mode no event pulse sets a flag.
- R11: In loopback, a transmit-done pulse sets both flags. In listen-only and in sleep, transmit-done pulses are ignored and sending is not permitted.
- R12: The engine outputs track the running mode. The enable output is high in any mode other than configuration, sleep, loopback and listen-only each raise their own output, and the send permission is high only in normal and loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ev_tx_done | input | 1 | Engine pulse: transmission completed |
| ev_rx_done | input | 1 | Engine pulse: frame received |
| ev_bus_seen | input | 1 | Engine pulse: activity seen on the bus |
| eng_enable | output | 1 | Controller running (not configuration mode) |
| eng_sleep | output | 1 | Sleep mode running |
| eng_loopback | output | 1 | Loopback mode running |
| eng_listen_only | output | 1 | Listen-only mode running |
| tx_permit | output | 1 | Engine may start transmissions |

## Verification
A wrong running mode shows up in the status word and in the engine outputs one cycle after the write or wake pulse that caused it. This is because both are decoded directly from a single mode register. A flag that is lost or set by mistake appears at offset 0x1C one cycle after the event or the clear. A stored selection code that is corrupted stays hidden until the next enable, but it can be seen at once by reading offset 0x04. For that reason the bench compares the read word and all engine outputs against its model on every cycle.

// File: rtl/can_mr_pkg.sv
package can_mr_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Register offsets (byte addresses of 32-bit words)
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_FCLR = 8'h24;

    localparam int EN_BIT = 1;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] CODE_NORMAL = 3'd0;
    localparam logic [SEL_W-1:0] CODE_SLEEP  = 3'd1;
    localparam logic [SEL_W-1:0] CODE_LOOP   = 3'd2;
    localparam logic [SEL_W-1:0] CODE_SNOOP  = 3'd4;

    // Status bit positions per running mode
    localparam int ST_NORMAL = 3;
    localparam int ST_LOOP   = 1;
    localparam int ST_SLEEP  = 2;
    localparam int ST_SNOOP  = 12;

    // Interrupt sources
    localparam int IRQ_N  = 2;
    localparam int IRQ_TX = 0;
    localparam int IRQ_RX = 1;

    typedef enum logic [2:0] {
        ACT_CFG,
        ACT_NORMAL,
        ACT_SLEEP,
        ACT_LOOP,
        ACT_SNOOP
    } act_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_wr_t;

    function automatic int irq_pos(input int idx);
        return (idx == IRQ_TX) ? 1 : 4;
    endfunction

    function automatic logic code_ok(input logic [DATA_W-1:0] w);
        return (w == DATA_W'(CODE_NORMAL)) || (w == DATA_W'(CODE_SLEEP)) ||
               (w == DATA_W'(CODE_LOOP))   || (w == DATA_W'(CODE_SNOOP));
    endfunction

    function automatic act_e code_to_act(input logic [SEL_W-1:0] c);
        case (c)
            CODE_SLEEP: return ACT_SLEEP;
            CODE_LOOP:  return ACT_LOOP;
            CODE_SNOOP: return ACT_SNOOP;
            default:    return ACT_NORMAL;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input act_e a);
        logic [DATA_W-1:0] s;
        s = '0;
        case (a)
            ACT_NORMAL: s[ST_NORMAL] = 1'b1;
            ACT_SLEEP:  s[ST_SLEEP]  = 1'b1;
            ACT_LOOP:   s[ST_LOOP]   = 1'b1;
            ACT_SNOOP:  s[ST_SNOOP]  = 1'b1;
            default:    s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/can_mr_mode_ctl.sv
module can_mr_mode_ctl
    import can_mr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bus_wr_t             wr,
    input  logic                bus_act,
    output act_e                act,
    output logic                en_q,
    output logic [SEL_W-1:0]    sel_q
);

    logic ctrl_hit;
    logic mode_hit;

    assign ctrl_hit = wr.wr && (wr.addr == OFS_CTRL);
    assign mode_hit = wr.wr && (wr.addr == OFS_MODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            sel_q <= CODE_NORMAL;
            act   <= ACT_CFG;
        end else begin
            if (ctrl_hit) begin
                en_q <= wr.wdata[EN_BIT];
                if (!wr.wdata[EN_BIT]) begin
                    act <= ACT_CFG;
                end else if (!en_q) begin
                    act <= code_to_act(sel_q);
                end
            end else if (act == ACT_SLEEP && bus_act) begin
                act <= ACT_NORMAL;
            end
            if (mode_hit && !en_q && code_ok(wr.wdata)) begin
                sel_q <= wr.wdata[SEL_W-1:0];
            end
        end
    end

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        en_q |=> $stable(sel_q)); // R4

    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_SLEEP && bus_act && !ctrl_hit) |=> (act == ACT_NORMAL)); // R7

    AST_CFG_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (act == ACT_CFG)); // R2

endmodule

// File: rtl/can_mr_irq.sv
module can_mr_irq
    import can_mr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  act_e             act,
    input  logic             ev_tx,
    input  logic             ev_rx,
    input  bus_wr_t          wr,
    output logic [IRQ_N-1:0] flags
);

    logic [IRQ_N-1:0] set_v;
    logic             clr_hit;

    assign clr_hit = wr.wr && (wr.addr == OFS_FCLR);

    always_comb begin
        set_v         = '0;
        set_v[IRQ_TX] = ev_tx && (act == ACT_NORMAL || act == ACT_LOOP);
        set_v[IRQ_RX] = (ev_rx && act != ACT_CFG) || (ev_tx && act == ACT_LOOP);
    end

    for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (set_v[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_hit && wr.wdata[irq_pos(i)]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    AST_CFG_NO_EVENTS: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_CFG) |=> ((flags & ~$past(flags)) == '0)); // R10

    AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (ev_tx && act == ACT_NORMAL) |=> flags[IRQ_TX]); // R9

    AST_LOOP_ECHO: assert property (@(posedge clk) disable iff (rst)
        (ev_tx && act == ACT_LOOP) |=> (flags[IRQ_TX] && flags[IRQ_RX])); // R11

    AST_SNOOP_NO_TXFLAG: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_SNOOP && !flags[IRQ_TX]) |=> !flags[IRQ_TX]); // R11

endmodule

// File: rtl/can_mr_regs.sv
module can_mr_regs
    import can_mr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_tx_done,
    input  logic              ev_rx_done,
    input  logic              ev_bus_seen,
    output logic              eng_enable,
    output logic              eng_sleep,
    output logic              eng_loopback,
    output logic              eng_listen_only,
    output logic              tx_permit
);

    bus_wr_t          wr;
    act_e             act;
    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic [IRQ_N-1:0] flags;
    logic [DATA_W-1:0] flag_word;

    assign wr = '{wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    can_mr_mode_ctl u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .bus_act (ev_bus_seen),
        .act     (act),
        .en_q    (en_q),
        .sel_q   (sel_q)
    );

    can_mr_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .ev_tx (ev_tx_done),
        .ev_rx (ev_rx_done),
        .wr    (wr),
        .flags (flags)
    );

    always_comb begin
        flag_word = '0;
        for (int i = 0; i < IRQ_N; i++) begin
            flag_word[irq_pos(i)] = flags[i];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: bus_rdata[EN_BIT] = en_q;
            OFS_MODE: bus_rdata[SEL_W-1:0] = sel_q;
            OFS_STAT: bus_rdata = status_word(act);
            OFS_FLAG: bus_rdata = flag_word;
            default:  bus_rdata = '0;
        endcase
    end

    assign eng_enable      = (act != ACT_CFG);
    assign eng_sleep       = (act == ACT_SLEEP);
    assign eng_loopback    = (act == ACT_LOOP);
    assign eng_listen_only = (act == ACT_SNOOP);
    assign tx_permit       = (act == ACT_NORMAL) || (act == ACT_LOOP);

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_STAT) |-> ($onehot0(bus_rdata) && ((bus_rdata == '0) == !eng_enable))); // R5

    AST_LISTEN_NO_TX: assert property (@(posedge clk) disable iff (rst)
        (eng_listen_only || eng_sleep) |-> !tx_permit); // R11

    AST_ENABLE_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL && !bus_wdata[EN_BIT]) |=> !eng_enable); // R2

endmodule

// File: tb/tb_can_mr_regs.sv
module tb_can_mr_regs;

    localparam int CLK_PERIOD = 10;

    localparam int M_CFG = 0, M_NORM = 1, M_SLEEP = 2, M_LOOP = 3, M_SNOOP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        ev_tx_done = 1'b0, ev_rx_done = 1'b0, ev_bus_seen = 1'b0;
    logic        eng_enable, eng_sleep, eng_loopback, eng_listen_only, tx_permit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    bit          m_en;
    int          m_sel;
    int          m_act;
    bit          m_ftx, m_frx;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_mr_regs dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_bus_seen(ev_bus_seen),
        .eng_enable(eng_enable), .eng_sleep(eng_sleep), .eng_loopback(eng_loopback),
        .eng_listen_only(eng_listen_only), .tx_permit(tx_permit)
    );

    function automatic int sel_to_mode(input int c);
        if (c == 1) return M_SLEEP;
        if (c == 2) return M_LOOP;
        if (c == 4) return M_SNOOP;
        return M_NORM;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] r;
        r = 32'h0;
        if (a == 8'h00) r[1] = m_en;
        else if (a == 8'h04) r = 32'(m_sel);
        else if (a == 8'h18) begin
            if (m_act == M_NORM)  r = 32'h0000_0008;
            if (m_act == M_LOOP)  r = 32'h0000_0002;
            if (m_act == M_SLEEP) r = 32'h0000_0004;
            if (m_act == M_SNOOP) r = 32'h0000_1000;
        end else if (a == 8'h1C) begin
            r[1] = m_ftx;
            r[4] = m_frx;
        end
        return r;
    endfunction

    task automatic model_edge(input bit w, input logic [7:0] a, input logic [31:0] d,
                              input bit tx, input bit rx, input bit bs);
        bit n_en; int n_sel; int n_act; bit n_ftx; bit n_frx;
        bit stx; bit srx;
        n_en = m_en; n_sel = m_sel; n_act = m_act; n_ftx = m_ftx; n_frx = m_frx;
        if (w && a == 8'h00) begin
            n_en = d[1];
            if (!d[1]) n_act = M_CFG;
            else if (!m_en) n_act = sel_to_mode(m_sel);
        end else if (m_act == M_SLEEP && bs) begin
            n_act = M_NORM;
        end
        if (w && a == 8'h04 && !m_en && (d == 0 || d == 1 || d == 2 || d == 4))
            n_sel = int'(d);
        stx = tx && (m_act == M_NORM || m_act == M_LOOP);
        srx = (rx && m_act != M_CFG) || (tx && m_act == M_LOOP);
        if (w && a == 8'h24) begin
            if (d[1]) n_ftx = 1'b0;
            if (d[4]) n_frx = 1'b0;
        end
        if (stx) n_ftx = 1'b1;
        if (srx) n_frx = 1'b1;
        m_en = n_en; m_sel = n_sel; m_act = n_act; m_ftx = n_ftx; m_frx = n_frx;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act_v, input logic [31:0] exp_v);
        n_checks++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
        end
    endtask

    task automatic compare_all(input string tag, input logic [7:0] ra);
        check(tag, "rdata", bus_rdata, m_read(ra));
        check(tag, "eng_enable", 32'(eng_enable), 32'(m_act != M_CFG));
        check(tag, "eng_sleep", 32'(eng_sleep), 32'(m_act == M_SLEEP));
        check(tag, "eng_loopback", 32'(eng_loopback), 32'(m_act == M_LOOP));
        check(tag, "eng_listen_only", 32'(eng_listen_only), 32'(m_act == M_SNOOP));
        check(tag, "tx_permit", 32'(tx_permit), 32'(m_act == M_NORM || m_act == M_LOOP));
    endtask

    // drive one cycle, update model at the edge, then read back ra
    task automatic step(input string tag, input bit w, input logic [7:0] a,
                        input logic [31:0] d, input bit tx, input bit rx, input bit bs,
                        input logic [7:0] ra);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        ev_tx_done = tx; ev_rx_done = rx; ev_bus_seen = bs;
        @(posedge clk);
        model_edge(w, a, d, tx, rx, bs);
        #1;
        bus_wr = 1'b0; ev_tx_done = 1'b0; ev_rx_done = 1'b0; ev_bus_seen = 1'b0;
        bus_addr = ra; bus_wdata = 32'h0;
        #1;
        compare_all(tag, ra);
    endtask

    task automatic wr_reg(input string tag, input logic [7:0] a, input logic [31:0] d,
                          input logic [7:0] ra);
        step(tag, 1'b1, a, d, 1'b0, 1'b0, 1'b0, ra);
    endtask

    task automatic ev(input string tag, input bit tx, input bit rx, input bit bs,
                      input logic [7:0] ra);
        step(tag, 1'b0, 8'h00, 32'h0, tx, rx, bs, ra);
    endtask

    task automatic idle_read(input string tag, input logic [7:0] ra);
        step(tag, 1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0, ra);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        m_en = 1'b0; m_sel = 0; m_act = M_CFG; m_ftx = 1'b0; m_frx = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state on every word
        idle_read("R1", 8'h00);
        idle_read("R1", 8'h04);
        idle_read("R1", 8'h18);
        idle_read("R1", 8'h1C);

        // R10: events in configuration mode are dropped
        ev("R10", 1'b1, 1'b1, 1'b1, 8'h1C);

        // R3: legal and illegal mode codes
        wr_reg("R3", 8'h04, 32'h2, 8'h04);
        wr_reg("R3", 8'h04, 32'h3, 8'h04);
        wr_reg("R3", 8'h04, 32'h1_0004, 8'h04);

        // R6/R5: enable starts loopback, status bit 1
        wr_reg("R6", 8'h00, 32'h2, 8'h18);
        idle_read("R2", 8'h00);
        // R4: mode write while enabled ignored
        wr_reg("R4", 8'h04, 32'h0, 8'h04);
        idle_read("R5", 8'h18);

        // R11: loopback echo sets both flags
        ev("R11", 1'b1, 1'b0, 1'b0, 8'h1C);
        // R9: clear both, then set wins over clear
        wr_reg("R9", 8'h24, 32'h12, 8'h1C);
        step("R9", 1'b1, 8'h24, 32'h10, 1'b0, 1'b1, 1'b0, 8'h1C);
        wr_reg("R9", 8'h24, 32'h2, 8'h1C);
        wr_reg("R9", 8'h24, 32'h10, 8'h1C);

        // R2: disable returns to configuration mode
        wr_reg("R2", 8'h00, 32'h0, 8'h18);
        ev("R10", 1'b1, 1'b1, 1'b0, 8'h1C);

        // listen-only
        wr_reg("R3", 8'h04, 32'h4, 8'h04);
        wr_reg("R6", 8'h00, 32'h2, 8'h18);
        ev("R11", 1'b1, 1'b0, 1'b0, 8'h1C);
        ev("R8", 1'b0, 1'b1, 1'b0, 8'h1C);
        wr_reg("R6", 8'h00, 32'h2, 8'h18);
        wr_reg("R9", 8'h24, 32'hFFFF_FFFF, 8'h1C);

        // sleep and wake
        wr_reg("R2", 8'h00, 32'h0, 8'h18);
        wr_reg("R3", 8'h04, 32'h1, 8'h04);
        wr_reg("R6", 8'h00, 32'h2, 8'h18);
        ev("R11", 1'b1, 1'b0, 1'b0, 8'h1C);
        ev("R12", 1'b0, 1'b0, 1'b0, 8'h18);
        ev("R7", 1'b0, 1'b0, 1'b1, 8'h18);
        idle_read("R7", 8'h04);
        ev("R8", 1'b0, 1'b1, 1'b0, 8'h1C);

        // normal mode: transmit sets bit 1 only
        wr_reg("R2", 8'h00, 32'h0, 8'h18);
        wr_reg("R3", 8'h04, 32'h0, 8'h04);
        wr_reg("R9", 8'h24, 32'h10, 8'h1C);
        wr_reg("R6", 8'h00, 32'h2, 8'h18);
        ev("R8", 1'b1, 1'b0, 1'b0, 8'h1C);
        idle_read("R8", 8'h1C);
        ev("R12", 1'b0, 1'b0, 1'b1, 8'h18);
        idle_read("R1", 8'h30);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule